// File: doc/BRIEF.md
# Loose Round-Robin Warp Issue Scheduler

Every cycle this block decides which of a group of supervised warps may send one instruction to an execution pipe. Each warp shows the head of its instruction buffer to the block. The head consists of a valid flag, a flag that says whether an instruction is present, the instruction PC, a two-bit op class and a ready flag from the scoreboard. Each warp also supplies the PC that its divergence stack currently expects. Three issue ports report whether they have a free slot: the SP pipe, the SFU pipe and the memory pipe.

Warps are examined in a rotating order. The order begins at the warp just after the one that most recently issued and wraps past the end of the list. Before any warp has issued, it begins at warp 0. A warp whose buffered PC disagrees with its stack, or whose buffer entry is valid but holds no instruction, is flushed and redirected if it is reached during the scan. The first warp that can be routed to a free port wins and ends the scan. When nothing issues, the cycle is classified as idle, waiting on a register dependency, or blocked by full pipes.

The decision is combinational within the cycle. Only the last-issued pointer is stored. A synchronous active-high reset clears that pointer back to "none".

Top module: `wsched_top`

## Requirements
- R1: After reset the pointer holds "none", so the scan starts at warp 0 and the lowest-numbered eligible warp issues first.
- R2: Once some warp w has issued, the scan in later cycles starts at warp w+1 and wraps from the last warp to warp 0.
- R3: The pointer moves only in a cycle in which a warp issues. Stalled and idle cycles leave the scan start unchanged.
- R4: A live warp with a valid buffer entry whose PC differs from its stack PC gets its flushMask bit set (flush and reload next-PC from the stack), and it does not issue.
- R5: A live warp whose buffer entry is valid but carries no instruction is flushed in the same way.
- R6: Only warps reached before the winning warp in scan order are flushed. Hazard warps after the winner are left alone. When nothing issues, every hazard warp is flushed.
- R7: Op class 2 (load, store, memory barrier) issues only on the memory port, and only when memFree is 1.
- R8: Op class 0 (ALU) goes only to SP when spFree is 1. Class 1 (SFU) goes only to SFU when sfuFree is 1. Class 3 (ALU that may use SFU) goes to SP when spFree is 1, otherwise to SFU when sfuFree is 1.
- R9: A warp whose exited bit is set is never issued or flushed.
- R10: At most one warp issues per cycle. issuePort is one-hot with bit0=SP, bit1=SFU, bit2=MEM, and is all zero when issueValid is 0.
- R11: stallCode is 0 when a warp issues. It is 1 when no live warp has a valid instruction, 2 when valid instructions exist but none is scoreboard-ready, and 3 when some instruction is ready but no port could take it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warpExited | input | NUM_WARPS | Per-warp exited flag |
| ibValid | input | NUM_WARPS | Buffer head valid |
| ibHasInst | input | NUM_WARPS | Buffer head holds an instruction |
| ibPc | input | NUM_WARPS*PC_W | Buffered instruction PC per warp |
| ibOp | input | 2*NUM_WARPS | Op class per warp (0 ALU, 1 SFU, 2 MEM, 3 ALU-or-SFU) |
| sbReady | input | NUM_WARPS | Scoreboard reports no pending hazard |
| stackPc | input | NUM_WARPS*PC_W | Expected PC from the divergence stack |
| spFree | input | 1 | SP port has a free slot |
| sfuFree | input | 1 | SFU port has a free slot |
| memFree | input | 1 | Memory port has a free slot |
| issueValid | output | 1 | A warp issues this cycle (issue-count strobe) |
| issueWarp | output | 4 | Index of the issuing warp |
| issuePort | output | 3 | One-hot target port |
| flushMask | output | NUM_WARPS | Warps to flush and redirect this cycle |
| stallCode | output | 2 | Cycle classification |

## Verification
The scan is driven first with sparse valid masks, which separate a start at warp 0 from a start at the anchored pointer, and then with full masks, which show whether the start advanced, held or wrapped. Port-pressure patterns pair each op class with each combination of busy ports. These show SP preference, the SFU fallback for class 3 and blocked memory ops. Mixed hazard patterns place stale PCs and empty entries both before and after the winner, which tells a scan-bounded flush from a global one. Reset in the middle of a run checks that the pointer really returns to "none".

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // Warp indices are carried at a fixed width; NUM_WARPS must not exceed 16.
  localparam int WARP_ID_W = 4;
  localparam int NUM_PORTS = 3;
  localparam int PORT_SP   = 0;
  localparam int PORT_SFU  = 1;
  localparam int PORT_MEM  = 2;

  typedef enum logic [1:0] {
    OP_ALU     = 2'd0,
    OP_SFU     = 2'd1,
    OP_MEM     = 2'd2,
    OP_ALU_SFU = 2'd3
  } opClass_e;

  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0,
    ST_IDLE   = 2'd1,
    ST_RAW    = 2'd2,
    ST_PIPE   = 2'd3
  } stall_e;

  // control -> datapath
  typedef struct packed {
    logic                 haveLast;
    logic [WARP_ID_W-1:0] lastWarp;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic                 issueHit;
    logic                 anyValid;
    logic                 anyReady;
    logic [WARP_ID_W-1:0] winWarp;
  } dpEvent_t;

endpackage

// File: rtl/wsched_lane.sv
module wsched_lane
  import wsched_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            exited,
  input  logic            bufValid,
  input  logic            hasInst,
  input  logic [PC_W-1:0] bufPc,
  input  logic [PC_W-1:0] expPc,
  input  logic [1:0]      opClass,
  input  logic            ready,
  input  logic            spFree,
  input  logic            sfuFree,
  input  logic            memFree,
  output logic            hazard,
  output logic            instValid,
  output logic            instReady,
  output logic            canIssue,
  output logic [NUM_PORTS-1:0] portSel
);

  logic live;
  logic pcOk;

  always_comb begin
    live      = !exited;
    pcOk      = (bufPc == expPc);
    hazard    = live && bufValid && (!hasInst || !pcOk);
    instValid = live && bufValid && hasInst && pcOk;
    instReady = instValid && ready;

    portSel = '0;
    unique case (opClass_e'(opClass))
      OP_MEM:     if (memFree) portSel[PORT_MEM] = 1'b1;
      OP_ALU:     if (spFree)  portSel[PORT_SP]  = 1'b1;
      OP_SFU:     if (sfuFree) portSel[PORT_SFU] = 1'b1;
      OP_ALU_SFU: begin
        if (spFree)       portSel[PORT_SP]  = 1'b1;
        else if (sfuFree) portSel[PORT_SFU] = 1'b1;
      end
      default: portSel = '0;
    endcase
    canIssue = instReady && (|portSel);
  end

endmodule

// File: rtl/wsched_dp.sv
module wsched_dp
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 16
) (
  input  logic [NUM_WARPS-1:0]      warpExited,
  input  logic [NUM_WARPS-1:0]      ibValid,
  input  logic [NUM_WARPS-1:0]      ibHasInst,
  input  logic [NUM_WARPS*PC_W-1:0] ibPc,
  input  logic [2*NUM_WARPS-1:0]    ibOp,
  input  logic [NUM_WARPS-1:0]      sbReady,
  input  logic [NUM_WARPS*PC_W-1:0] stackPc,
  input  logic                      spFree,
  input  logic                      sfuFree,
  input  logic                      memFree,
  input  ctrlStrobe_t               ctrl,
  output dpEvent_t                  evt,
  output logic [NUM_PORTS-1:0]      issuePort,
  output logic [NUM_WARPS-1:0]      flushMask
);

  logic [NUM_WARPS-1:0] hazard;
  logic [NUM_WARPS-1:0] instValid;
  logic [NUM_WARPS-1:0] instReady;
  logic [NUM_WARPS-1:0] canIssue;
  logic [NUM_PORTS-1:0] portSel [NUM_WARPS];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_lane
    wsched_lane #(.PC_W(PC_W)) lane (
      .exited    (warpExited[w]),
      .bufValid  (ibValid[w]),
      .hasInst   (ibHasInst[w]),
      .bufPc     (ibPc[w*PC_W +: PC_W]),
      .expPc     (stackPc[w*PC_W +: PC_W]),
      .opClass   (ibOp[2*w +: 2]),
      .ready     (sbReady[w]),
      .spFree    (spFree),
      .sfuFree   (sfuFree),
      .memFree   (memFree),
      .hazard    (hazard[w]),
      .instValid (instValid[w]),
      .instReady (instReady[w]),
      .canIssue  (canIssue[w]),
      .portSel   (portSel[w])
    );
  end

  // Rotating scan: start after the last issuer, stop at the first winner.
  always_comb begin
    int  startIdx;
    int  idx;
    logic found;
    startIdx = 0;
    if (ctrl.haveLast && (int'(ctrl.lastWarp) < NUM_WARPS - 1))
      startIdx = int'(ctrl.lastWarp) + 1;
    found     = 1'b0;
    flushMask = '0;
    issuePort = '0;
    evt.winWarp = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      idx = startIdx + k;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!found) begin
        if (hazard[idx]) flushMask[idx] = 1'b1;
        if (canIssue[idx]) begin
          found       = 1'b1;
          evt.winWarp = WARP_ID_W'(idx);
          issuePort   = portSel[idx];
        end
      end
    end
    evt.issueHit = found;
    evt.anyValid = |instValid;
    evt.anyReady = |instReady;
  end

endmodule

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpEvent_t    evt,
  output ctrlStrobe_t ctrl,
  output logic [1:0]  stallCode
);

  logic                 haveLast;
  logic [WARP_ID_W-1:0] lastWarp;

  always_ff @(posedge clk) begin
    if (rst) begin
      haveLast <= 1'b0;
      lastWarp <= '0;
    end else if (evt.issueHit) begin
      haveLast <= 1'b1;
      lastWarp <= evt.winWarp;
    end
  end

  always_comb begin
    ctrl.haveLast = haveLast;
    ctrl.lastWarp = lastWarp;
    if (evt.issueHit)      stallCode = ST_ISSUED;
    else if (!evt.anyValid) stallCode = ST_IDLE;
    else if (!evt.anyReady) stallCode = ST_RAW;
    else                    stallCode = ST_PIPE;
  end

endmodule

// File: rtl/wsched_top.sv
module wsched_top
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_WARPS-1:0]      warpExited,
  input  logic [NUM_WARPS-1:0]      ibValid,
  input  logic [NUM_WARPS-1:0]      ibHasInst,
  input  logic [NUM_WARPS*PC_W-1:0] ibPc,
  input  logic [2*NUM_WARPS-1:0]    ibOp,
  input  logic [NUM_WARPS-1:0]      sbReady,
  input  logic [NUM_WARPS*PC_W-1:0] stackPc,
  input  logic                      spFree,
  input  logic                      sfuFree,
  input  logic                      memFree,
  output logic                      issueValid,
  output logic [WARP_ID_W-1:0]      issueWarp,
  output logic [NUM_PORTS-1:0]      issuePort,
  output logic [NUM_WARPS-1:0]      flushMask,
  output logic [1:0]                stallCode
);

  ctrlStrobe_t ctrl;
  dpEvent_t    evt;

  wsched_dp #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W)) dp (
    .warpExited (warpExited),
    .ibValid    (ibValid),
    .ibHasInst  (ibHasInst),
    .ibPc       (ibPc),
    .ibOp       (ibOp),
    .sbReady    (sbReady),
    .stackPc    (stackPc),
    .spFree     (spFree),
    .sfuFree    (sfuFree),
    .memFree    (memFree),
    .ctrl       (ctrl),
    .evt        (evt),
    .issuePort  (issuePort),
    .flushMask  (flushMask)
  );

  wsched_ctrl ctl (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .ctrl      (ctrl),
    .stallCode (stallCode)
  );

  assign issueValid = evt.issueHit;
  assign issueWarp  = evt.winWarp;

endmodule

// File: rtl/wsched_chk.sv
module wsched_chk
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_WARPS-1:0]      warpExited,
  input logic [NUM_WARPS-1:0]      ibValid,
  input logic [NUM_WARPS-1:0]      ibHasInst,
  input logic [NUM_WARPS*PC_W-1:0] ibPc,
  input logic [2*NUM_WARPS-1:0]    ibOp,
  input logic [NUM_WARPS*PC_W-1:0] stackPc,
  input logic                      spFree,
  input logic                      sfuFree,
  input logic                      memFree,
  input logic                      issueValid,
  input logic [WARP_ID_W-1:0]      issueWarp,
  input logic [NUM_PORTS-1:0]      issuePort,
  input logic [NUM_WARPS-1:0]      flushMask,
  input logic [1:0]                stallCode
);

  p_port_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> $onehot(issuePort));

  p_port_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> (issuePort == '0));

  p_stall_code_r11: assert property (@(posedge clk) disable iff (rst)
    issueValid == (stallCode == 2'd0));

  p_skip_exited_r9: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> !warpExited[issueWarp]);

  p_no_self_flush_r6: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> !flushMask[issueWarp]);

  p_mem_route_r7: assert property (@(posedge clk) disable iff (rst)
    issuePort[PORT_MEM] |-> (memFree && ibOp[int'(issueWarp)*2 +: 2] == 2'd2));

  p_sp_route_r8: assert property (@(posedge clk) disable iff (rst)
    issuePort[PORT_SP] |-> (spFree && ibOp[int'(issueWarp)*2] == 1'b0 ||
                            spFree && ibOp[int'(issueWarp)*2 +: 2] == 2'd3));

  p_sfu_route_r8: assert property (@(posedge clk) disable iff (rst)
    issuePort[PORT_SFU] |-> (sfuFree && ibOp[int'(issueWarp)*2] == 1'b1));

  // R5 is covered by the empty-entry half of this cause check.
  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_fl
    p_flush_cause_r4: assert property (@(posedge clk) disable iff (rst)
      flushMask[i] |-> (ibValid[i] && !warpExited[i] &&
        (!ibHasInst[i] || ibPc[i*PC_W +: PC_W] != stackPc[i*PC_W +: PC_W])));
  end

endmodule

bind wsched_top wsched_chk #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W)) chk (
  .clk        (clk),
  .rst        (rst),
  .warpExited (warpExited),
  .ibValid    (ibValid),
  .ibHasInst  (ibHasInst),
  .ibPc       (ibPc),
  .ibOp       (ibOp),
  .stackPc    (stackPc),
  .spFree     (spFree),
  .sfuFree    (sfuFree),
  .memFree    (memFree),
  .issueValid (issueValid),
  .issueWarp  (issueWarp),
  .issuePort  (issuePort),
  .flushMask  (flushMask),
  .stallCode  (stallCode)
);

// File: tb/wsched_top_test.sv
module wsched_top_test;

  localparam int N    = 8;
  localparam int PW   = 16;
  localparam int NV   = 18;
  localparam int VW   = 76;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    warpExited = '0;
  logic [N-1:0]    ibValid = '0;
  logic [N-1:0]    ibHasInst = '0;
  logic [N*PW-1:0] ibPc = '0;
  logic [2*N-1:0]  ibOp = '0;
  logic [N-1:0]    sbReady = '0;
  logic [N*PW-1:0] stackPc = '0;
  logic            spFree = 1'b0;
  logic            sfuFree = 1'b0;
  logic            memFree = 1'b0;
  logic            issueValid;
  logic [3:0]      issueWarp;
  logic [2:0]      issuePort;
  logic [N-1:0]    flushMask;
  logic [1:0]      stallCode;

  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  wsched_top #(.NUM_WARPS(N), .PC_W(PW)) uut (.*);

  // Fields, MSB first: exited, valid, hasInst, pcMatch, ready, ops[16],
  // free{mem,sfu,sp}, expValid, expWarp[3], expPort[3], expFlush[8], expStall[2].
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'h00,8'h24,8'hFF,8'hFF,8'hFF,16'h0000,3'b111, 1'b1,3'd2,3'b001,8'h00,2'd0},
    {8'h00,8'hFF,8'hFF,8'hFF,8'hFF,16'h0000,3'b111, 1'b1,3'd3,3'b001,8'h00,2'd0},
    {8'h00,8'hFF,8'hFF,8'hFF,8'h00,16'h0000,3'b111, 1'b0,3'd0,3'b000,8'h00,2'd2},
    {8'h00,8'hFF,8'hFF,8'hFF,8'hFF,16'h0000,3'b111, 1'b1,3'd4,3'b001,8'h00,2'd0},
    {8'h00,8'h00,8'hFF,8'hFF,8'hFF,16'h0000,3'b111, 1'b0,3'd0,3'b000,8'h00,2'd1},
    {8'h00,8'hFF,8'hFF,8'h9F,8'hFF,16'h0000,3'b111, 1'b1,3'd7,3'b001,8'h60,2'd0},
    {8'h01,8'hFF,8'hFF,8'hFF,8'hFF,16'h0000,3'b111, 1'b1,3'd1,3'b001,8'h00,2'd0},
    {8'h00,8'hFF,8'hFB,8'hBF,8'hFF,16'h0000,3'b111, 1'b1,3'd3,3'b001,8'h04,2'd0},
    {8'h00,8'h50,8'hFF,8'hFF,8'hFF,16'h0200,3'b011, 1'b1,3'd6,3'b001,8'h00,2'd0},
    {8'h00,8'h10,8'hFF,8'hFF,8'hFF,16'h0200,3'b111, 1'b1,3'd4,3'b100,8'h00,2'd0},
    {8'h00,8'h20,8'hFF,8'hFF,8'hFF,16'h0800,3'b011, 1'b0,3'd0,3'b000,8'h00,2'd3},
    {8'h00,8'h20,8'hFF,8'hFF,8'hFF,16'h0400,3'b111, 1'b1,3'd5,3'b010,8'h00,2'd0},
    {8'h00,8'h40,8'hFF,8'hFF,8'hFF,16'h3000,3'b111, 1'b1,3'd6,3'b001,8'h00,2'd0},
    {8'h00,8'h80,8'hFF,8'hFF,8'hFF,16'hC000,3'b110, 1'b1,3'd7,3'b010,8'h00,2'd0},
    {8'h00,8'h01,8'hFF,8'hFF,8'hFF,16'h0001,3'b101, 1'b0,3'd0,3'b000,8'h00,2'd3},
    {8'h00,8'h01,8'hFF,8'hFF,8'hFF,16'h0000,3'b110, 1'b0,3'd0,3'b000,8'h00,2'd3},
    {8'h00,8'h03,8'hFF,8'hFF,8'hFE,16'h0000,3'b110, 1'b0,3'd0,3'b000,8'h00,2'd3},
    {8'hFF,8'hFF,8'hFF,8'h00,8'hFF,16'h0000,3'b111, 1'b0,3'd0,3'b000,8'h00,2'd1}
  };

  localparam string VREQ [NV] = '{
    "R1 first issue from warp 0 scan", "R2 start after last issuer",
    "R11 RAW wait", "R3 pointer held over stall", "R11 idle",
    "R4 R6 stale PCs before winner", "R9 R2 exited skipped after wrap",
    "R5 R6 empty entry flushed, later hazard kept", "R7 MEM blocked, SP taken",
    "R7 MEM issue", "R7 R11 MEM busy pipe stall", "R8 SFU op to SFU",
    "R8 ALU-SFU prefers SP", "R8 ALU-SFU falls back to SFU",
    "R8 SFU op never to SP", "R8 ALU op never to SFU",
    "R11 one ready but blocked", "R9 all exited no flush"
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [VW-1:0] v, int n);
    logic [7:0] match;
    match = v[51:44];
    warpExited = v[75:68];
    ibValid    = v[67:60];
    ibHasInst  = v[59:52];
    sbReady    = v[43:36];
    ibOp       = v[35:20];
    {memFree, sfuFree, spFree} = v[19:17];
    for (int i = 0; i < N; i++) begin
      stackPc[i*PW +: PW] = 16'h0100 + 16'(i * 8) + 16'(n);
      ibPc[i*PW +: PW]    = stackPc[i*PW +: PW] ^ (match[i] ? 16'h0 : 16'h4);
    end
  endtask

  task automatic allGood(logic [7:0] valid);
    drive({8'h00, valid, 8'hFF, 8'hFF, 8'hFF, 16'h0000, 3'b111, 17'h0}, 0);
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state
    allGood(8'h00);
    repeat (3) @(posedge clk);
    #5;
    check("R1 R11 reset idle stall", 32'(stallCode), 32'd1);
    check("R10 reset no issue", 32'(issueValid), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v], v);
      #5;
      check(VREQ[v], 32'(issueValid), 32'(VEC[v][16]));
      if (VEC[v][16]) check(VREQ[v], 32'(issueWarp), 32'(VEC[v][15:13]));
      check(VREQ[v], 32'(issuePort), 32'(VEC[v][12:10]));
      check(VREQ[v], 32'(flushMask), 32'(VEC[v][9:2]));
      check(VREQ[v], 32'(stallCode), 32'(VEC[v][1:0]));
      @(negedge clk);
    end

    // R1: mid-run reset returns the pointer to none
    allGood(8'h08);
    #5;
    check("R2 lone warp 3 issues", 32'(issueWarp), 32'd3);
    @(negedge clk);
    rst = 1'b1;
    allGood(8'h00);
    @(negedge clk);
    rst = 1'b0;
    allGood(8'hFF);
    #5;
    check("R1 scan restarts at warp 0 after reset", 32'(issueWarp), 32'd0);
    @(negedge clk);
    #5;
    check("R2 next cycle warp 1", 32'(issueWarp), 32'd1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule